// File: doc/BRIEF.md
# Framed Command Packet Receiver

This block sits behind an I2C target's bit engine and address matcher. Once the device address of a write transfer has matched, it takes the data bytes one strobe at a time. It splits them into a feature byte, a command byte, a two-byte length, a payload of up to `MAX_PAYLOAD` bytes and a two-byte check value. Each payload byte is passed straight on to a payload buffer, together with its index.

A reflected CRC-16 is computed over every byte from the feature byte through the last payload byte. When the transfer's stop condition arrives, the block compares this CRC with the value received. On a match it raises a one-cycle command-valid strobe, which presents the feature, the command and the length to a dispatcher. On a mismatch it raises a CRC-error strobe. The block raises a receive-error strobe when a packet is cut short, is too long, or declares an illegal length. A start condition at any point restarts framing.

The state machine has these states. `ST_IDLE` waits for a start. `ST_FEAT`, `ST_OP`, `ST_LEN_HI` and `ST_LEN_LO` take the four header bytes. `ST_BODY` takes the payload bytes. `ST_CRC_LO` and `ST_CRC_HI` take the check bytes. `ST_TAIL` waits for the stop. `ST_DRAIN` discards bytes after an error.

The transitions are as follows:
- Start goes from any state to `ST_FEAT`.
- Stop goes from any state to `ST_IDLE`.
- An accepted byte moves `ST_FEAT` → `ST_OP` → `ST_LEN_HI` → `ST_LEN_LO`.
- From `ST_LEN_LO`, an accepted byte goes to `ST_DRAIN` if the length is illegal, to `ST_CRC_LO` if the length is zero, and to `ST_BODY` otherwise.
- `ST_BODY` stays in `ST_BODY` until the last payload byte, which goes to `ST_CRC_LO`.
- An accepted byte then moves `ST_CRC_LO` → `ST_CRC_HI` → `ST_TAIL`.
- An accepted byte in `ST_TAIL` goes to `ST_DRAIN`.
- `ST_IDLE` and `ST_DRAIN` hold on bytes.

Top module: `cmd_frame_rx`

## Requirements
- R1: While reset is asserted, and after it is released with no input activity, `cmd_vld_o`, `crc_err_o`, `rx_err_o` and `pl_we_o` are all 0.
- R2: After a start, the first accepted byte is the feature and the second is the command. The next two bytes form the length, most significant byte first. On `cmd_vld_o` these appear unchanged on `cmd_feat_o`, `cmd_op_o` and `cmd_len_o`.
- R3: Payload byte i (counted from 0) appears on `pl_data_o` with `pl_idx_o` = i and `pl_we_o` = 1. This happens in the cycle after the clock edge that accepted the byte, in arrival order, for exactly `length` bytes.
- R4: The CRC starts at 0xFFFF and is updated one byte at a time, LSB first, with the reversed polynomial 0x8408 and no final XOR. It covers the feature byte through the last payload byte. The received value is taken low byte first. If the two values match when a stop arrives in `ST_TAIL`, `cmd_vld_o` pulses for one cycle after the edge that sampled the stop.
- R5: If the received CRC differs from the computed one when the stop arrives in `ST_TAIL`, `crc_err_o` pulses for one cycle and `cmd_vld_o` stays 0.
- R6: A length above `MAX_PAYLOAD` pulses `rx_err_o` once, in the cycle after the second length byte is accepted. The block then writes no payload and produces no further result until the next start.
- R7: A stop that arrives after a start but before the second CRC byte has been accepted pulses `rx_err_o` once, and produces no `cmd_vld_o` and no `crc_err_o`.
- R8: A start during a packet discards that packet, restarts framing at the feature byte and reinitialises the CRC. A complete packet that follows is then accepted.
- R9: Bytes that arrive with no start, or after an error before the next start, cause no payload writes and no result strobes.
- R10: At most one of `cmd_vld_o`, `crc_err_o` and `rx_err_o` is high in any cycle, and a result strobe never lasts more than one cycle.
- R11: A byte accepted after the second CRC byte, before the stop, pulses `rx_err_o` and discards the packet.
- R12: A zero length is legal. In that case the CRC bytes follow the length directly, and no payload write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start (or repeated start) seen, one-cycle strobe |
| stop_i | input | 1 | Stop seen, one-cycle strobe |
| byte_vld_i | input | 1 | A received data byte is on `byte_i` |
| byte_i | input | 8 | Received data byte |
| cmd_vld_o | output | 1 | Validated command, one-cycle strobe |
| cmd_feat_o | output | 8 | Feature byte of the last packet |
| cmd_op_o | output | 8 | Command byte of the last packet |
| cmd_len_o | output | LEN_W | Payload length of the last legal packet |
| crc_err_o | output | 1 | CRC mismatch, one-cycle strobe |
| rx_err_o | output | 1 | Framing error (truncated, too long, illegal length), one-cycle strobe |
| pl_we_o | output | 1 | Payload byte write strobe |
| pl_idx_o | output | IDX_W | Payload buffer index of the written byte |
| pl_data_o | output | 8 | Payload byte being written |

## Verification
The bench builds the block with `MAX_PAYLOAD` = 8. At that size it can send every legal length from 0 up to and including the limit, both with an intact and with a corrupted CRC. It can also send the first illegal length, 9, alongside 256 and 0xFFFF. With a 3-byte payload the frame is only nine bytes long, so a stop can be placed after each possible number of bytes. The expected CRC is computed in the bench in the unreflected MSB-first form, with each byte and the result bit-reversed.

// File: rtl/cmd_rx_pkg.sv
package cmd_rx_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FEAT,
        ST_OP,
        ST_LEN_HI,
        ST_LEN_LO,
        ST_BODY,
        ST_CRC_LO,
        ST_CRC_HI,
        ST_TAIL,
        ST_DRAIN
    } rx_state_t;

    localparam logic [15:0] CRC_SEED     = 16'hFFFF;
    localparam logic [15:0] CRC_POLY_REV = 16'h8408;

    // One byte of the reflected CRC-16, LSB first.
    function automatic logic [15:0] crc_step_byte(input logic [15:0] c_in,
                                                  input logic [7:0]  d);
        logic [15:0] c;
        c = c_in ^ {8'h00, d};
        for (int b = 0; b < 8; b++) begin
            c = c[0] ? ((c >> 1) ^ CRC_POLY_REV) : (c >> 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/cmd_rx_crc.sv
module cmd_rx_crc
    import cmd_rx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init_i,
    input  logic        upd_i,
    input  logic [7:0]  data_i,
    output logic [15:0] crc_o
);

    logic [15:0] crc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= CRC_SEED;
        end else if (init_i) begin
            crc_q <= CRC_SEED;
        end else if (upd_i) begin
            crc_q <= crc_step_byte(crc_q, data_i);
        end
    end

    assign crc_o = crc_q;

endmodule

// File: rtl/cmd_rx_fsm.sv
module cmd_rx_fsm
    import cmd_rx_pkg::*;
#(
    parameter int MAX_PAYLOAD = 256,
    parameter int LEN_W       = $clog2(MAX_PAYLOAD + 1),
    parameter int IDX_W       = $clog2(MAX_PAYLOAD)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             byte_vld_i,
    input  logic [7:0]       byte_i,
    output logic             crc_upd_o,
    output logic             feat_ld_o,
    output logic             op_ld_o,
    output logic             body_wr_o,
    output logic             crc_lo_ld_o,
    output logic             crc_hi_ld_o,
    output logic             end_o,
    output logic             abort_o,
    output logic [LEN_W-1:0] len_o,
    output logic [IDX_W-1:0] idx_o
);

    localparam logic [15:0]      MAX_LEN16 = 16'(MAX_PAYLOAD);
    localparam logic [LEN_W-1:0] ONE       = LEN_W'(1);

    rx_state_t        st_q, st_d;
    logic [7:0]       len_hi_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] cnt_q;

    logic        take;
    logic [15:0] len_full;
    logic        len_bad;
    logic        last_body;
    logic        in_frame;

    assign take      = byte_vld_i & ~start_i & ~stop_i;
    assign len_full  = {len_hi_q, byte_i};
    assign len_bad   = len_full > MAX_LEN16;
    assign last_body = (cnt_q + ONE) == len_q;
    assign in_frame  = st_q inside {ST_FEAT, ST_OP, ST_LEN_HI, ST_LEN_LO,
                                    ST_BODY, ST_CRC_LO, ST_CRC_HI};

    // Next-state logic
    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d = ST_FEAT;
        end else if (stop_i) begin
            st_d = ST_IDLE;
        end else if (take) begin
            unique case (st_q)
                ST_IDLE:   st_d = ST_IDLE;
                ST_FEAT:   st_d = ST_OP;
                ST_OP:     st_d = ST_LEN_HI;
                ST_LEN_HI: st_d = ST_LEN_LO;
                ST_LEN_LO: st_d = len_bad ? ST_DRAIN :
                                  (len_full == 16'd0) ? ST_CRC_LO : ST_BODY;
                ST_BODY:   st_d = last_body ? ST_CRC_LO : ST_BODY;
                ST_CRC_LO: st_d = ST_CRC_HI;
                ST_CRC_HI: st_d = ST_TAIL;
                ST_TAIL:   st_d = ST_DRAIN;
                ST_DRAIN:  st_d = ST_DRAIN;
                default:   st_d = ST_IDLE;
            endcase
        end
    end

    // State register and framing counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            len_hi_q <= 8'h00;
            len_q    <= '0;
            cnt_q    <= '0;
        end else begin
            st_q <= st_d;
            if (start_i) begin
                cnt_q <= '0;
            end else if (take) begin
                if (st_q == ST_LEN_HI) begin
                    len_hi_q <= byte_i;
                end
                if (st_q == ST_LEN_LO && !len_bad) begin
                    len_q <= len_full[LEN_W-1:0];
                    cnt_q <= '0;
                end
                if (st_q == ST_BODY) begin
                    cnt_q <= cnt_q + ONE;
                end
            end
        end
    end

    // Event outputs
    always_comb begin
        crc_upd_o   = take && (st_q inside {ST_FEAT, ST_OP, ST_LEN_HI,
                                            ST_LEN_LO, ST_BODY});
        feat_ld_o   = take && (st_q == ST_FEAT);
        op_ld_o     = take && (st_q == ST_OP);
        body_wr_o   = take && (st_q == ST_BODY);
        crc_lo_ld_o = take && (st_q == ST_CRC_LO);
        crc_hi_ld_o = take && (st_q == ST_CRC_HI);
        end_o       = stop_i && !start_i && (st_q == ST_TAIL);
        abort_o     = (stop_i && !start_i && in_frame)
                    || (take && (st_q == ST_LEN_LO) && len_bad)
                    || (take && (st_q == ST_TAIL));
        len_o       = len_q;
        idx_o       = cnt_q[IDX_W-1:0];
    end

endmodule

// File: rtl/cmd_frame_rx.sv
module cmd_frame_rx
    import cmd_rx_pkg::*;
#(
    parameter int  MAX_PAYLOAD = 256,
    localparam int LEN_W       = $clog2(MAX_PAYLOAD + 1),
    localparam int IDX_W       = $clog2(MAX_PAYLOAD)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             byte_vld_i,
    input  logic [7:0]       byte_i,
    output logic             cmd_vld_o,
    output logic [7:0]       cmd_feat_o,
    output logic [7:0]       cmd_op_o,
    output logic [LEN_W-1:0] cmd_len_o,
    output logic             crc_err_o,
    output logic             rx_err_o,
    output logic             pl_we_o,
    output logic [IDX_W-1:0] pl_idx_o,
    output logic [7:0]       pl_data_o
);

    logic             crc_upd, feat_ld, op_ld, body_wr;
    logic             crc_lo_ld, crc_hi_ld, frame_end, frame_abort;
    logic [LEN_W-1:0] len_w;
    logic [IDX_W-1:0] idx_w;
    logic [15:0]      crc_calc;
    logic [7:0]       crc_rx_lo_q, crc_rx_hi_q;
    logic             crc_match;

    cmd_rx_fsm #(
        .MAX_PAYLOAD (MAX_PAYLOAD),
        .LEN_W       (LEN_W),
        .IDX_W       (IDX_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .stop_i      (stop_i),
        .byte_vld_i  (byte_vld_i),
        .byte_i      (byte_i),
        .crc_upd_o   (crc_upd),
        .feat_ld_o   (feat_ld),
        .op_ld_o     (op_ld),
        .body_wr_o   (body_wr),
        .crc_lo_ld_o (crc_lo_ld),
        .crc_hi_ld_o (crc_hi_ld),
        .end_o       (frame_end),
        .abort_o     (frame_abort),
        .len_o       (len_w),
        .idx_o       (idx_w)
    );

    cmd_rx_crc u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .init_i (start_i),
        .upd_i  (crc_upd),
        .data_i (byte_i),
        .crc_o  (crc_calc)
    );

    assign crc_match = ({crc_rx_hi_q, crc_rx_lo_q} == crc_calc);
    assign cmd_len_o = len_w;

    // Output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_vld_o   <= 1'b0;
            crc_err_o   <= 1'b0;
            rx_err_o    <= 1'b0;
            pl_we_o     <= 1'b0;
            pl_idx_o    <= '0;
            pl_data_o   <= 8'h00;
            cmd_feat_o  <= 8'h00;
            cmd_op_o    <= 8'h00;
            crc_rx_lo_q <= 8'h00;
            crc_rx_hi_q <= 8'h00;
        end else begin
            cmd_vld_o <= frame_end && crc_match;
            crc_err_o <= frame_end && !crc_match;
            rx_err_o  <= frame_abort;
            pl_we_o   <= body_wr;
            if (body_wr) begin
                pl_idx_o  <= idx_w;
                pl_data_o <= byte_i;
            end
            if (feat_ld)   cmd_feat_o  <= byte_i;
            if (op_ld)     cmd_op_o    <= byte_i;
            if (crc_lo_ld) crc_rx_lo_q <= byte_i;
            if (crc_hi_ld) crc_rx_hi_q <= byte_i;
        end
    end

endmodule

// File: rtl/cmd_frame_rx_chk.sv
module cmd_frame_rx_chk #(
    parameter int  MAX_PAYLOAD = 256,
    localparam int LEN_W       = $clog2(MAX_PAYLOAD + 1),
    localparam int IDX_W       = $clog2(MAX_PAYLOAD)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             stop_i,
    input logic             byte_vld_i,
    input logic             cmd_vld_o,
    input logic [LEN_W-1:0] cmd_len_o,
    input logic             crc_err_o,
    input logic             rx_err_o,
    input logic             pl_we_o,
    input logic [IDX_W-1:0] pl_idx_o
);

    localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(MAX_PAYLOAD);

    p_one_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_vld_o, crc_err_o, rx_err_o}));

    p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld_o || crc_err_o) |=> !(cmd_vld_o || crc_err_o));

    p_result_after_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld_o || crc_err_o) |-> ($past(stop_i) && !$past(start_i)));

    p_len_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_vld_o |-> (cmd_len_o <= MAX_LEN));

    p_write_from_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pl_we_o |-> $past(byte_vld_i));

    p_write_in_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pl_we_o && $past(pl_we_o) && !$past(start_i, 2)) |->
            (pl_idx_o == $past(pl_idx_o) + IDX_W'(1)));

    p_start_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !(cmd_vld_o || crc_err_o || rx_err_o || pl_we_o));

endmodule

bind cmd_frame_rx cmd_frame_rx_chk #(.MAX_PAYLOAD(MAX_PAYLOAD)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .stop_i     (stop_i),
    .byte_vld_i (byte_vld_i),
    .cmd_vld_o  (cmd_vld_o),
    .cmd_len_o  (cmd_len_o),
    .crc_err_o  (crc_err_o),
    .rx_err_o   (rx_err_o),
    .pl_we_o    (pl_we_o),
    .pl_idx_o   (pl_idx_o)
);

// File: tb/cmd_frame_rx_bench.sv
module cmd_frame_rx_bench;

    localparam int MAXP = 8;
    localparam int LW   = $clog2(MAXP + 1);
    localparam int IW   = $clog2(MAXP);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start_i, stop_i, byte_vld_i;
    logic [7:0]    byte_i;
    logic          cmd_vld_o, crc_err_o, rx_err_o, pl_we_o;
    logic [7:0]    cmd_feat_o, cmd_op_o, pl_data_o;
    logic [LW-1:0] cmd_len_o;
    logic [IW-1:0] pl_idx_o;

    cmd_frame_rx #(.MAX_PAYLOAD(MAXP)) u_cmd_frame_rx (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .byte_vld_i(byte_vld_i), .byte_i(byte_i),
        .cmd_vld_o(cmd_vld_o), .cmd_feat_o(cmd_feat_o), .cmd_op_o(cmd_op_o),
        .cmd_len_o(cmd_len_o), .crc_err_o(crc_err_o), .rx_err_o(rx_err_o),
        .pl_we_o(pl_we_o), .pl_idx_o(pl_idx_o), .pl_data_o(pl_data_o)
    );

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    int n_vld, n_crc, n_rx, n_we, we_bad;
    int r10_bad = 0;
    bit prev_res = 1'b0;
    logic [7:0] got_feat, got_op;
    int got_len;
    logic [7:0] exp_pl [0:MAXP-1];
    logic [7:0] fr [0:63];
    int fr_n;

    // Monitor: sample just after each active edge
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            int cur;
            cur = int'(cmd_vld_o) + int'(crc_err_o) + int'(rx_err_o);
            if (cur > 1 || (cur > 0 && prev_res)) r10_bad++;
            prev_res = (cur > 0);
            if (cmd_vld_o) begin
                n_vld++;
                got_feat = cmd_feat_o;
                got_op   = cmd_op_o;
                got_len  = int'(cmd_len_o);
            end
            if (crc_err_o) n_crc++;
            if (rx_err_o)  n_rx++;
            if (pl_we_o) begin
                if (n_we >= MAXP || int'(pl_idx_o) != n_we ||
                    pl_data_o != exp_pl[n_we]) we_bad++;
                n_we++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    task automatic clr_sb();
        n_vld = 0; n_crc = 0; n_rx = 0; n_we = 0; we_bad = 0;
        got_feat = 8'h00; got_op = 8'h00; got_len = -1;
    endtask

    function automatic logic [7:0] rev8(input logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = v[7-i];
        return r;
    endfunction

    function automatic logic [15:0] rev16(input logic [15:0] v);
        logic [15:0] r;
        for (int i = 0; i < 16; i++) r[i] = v[15-i];
        return r;
    endfunction

    // Unreflected MSB-first form with reflected data and result
    function automatic logic [15:0] ref_crc(input int n);
        logic [15:0] c;
        c = 16'hFFFF;
        for (int i = 0; i < n; i++) begin
            c = c ^ {rev8(fr[i]), 8'h00};
            for (int b = 0; b < 8; b++)
                c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
        end
        return rev16(c);
    endfunction

    task automatic build(input logic [7:0] feat, input logic [7:0] op,
                         input int len, input int seed, input bit bad);
        logic [15:0] c;
        fr[0] = feat; fr[1] = op;
        fr[2] = 8'(len >> 8); fr[3] = 8'(len);
        if (len > MAXP) begin
            for (int i = 0; i < 5; i++) fr[4+i] = 8'(8'hA0 + i);
            fr_n = 9;
        end else begin
            for (int i = 0; i < len; i++) begin
                fr[4+i]   = 8'(seed * 37 + i * 29 + 3);
                exp_pl[i] = fr[4+i];
            end
            c = ref_crc(4 + len);
            fr[4+len] = c[7:0] ^ (bad ? 8'h01 : 8'h00);
            fr[5+len] = c[15:8];
            fr_n = 6 + len;
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); stop_i = 1'b1;
        @(negedge clk); stop_i = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk); byte_vld_i = 1'b1; byte_i = b;
        @(negedge clk); byte_vld_i = 1'b0;
    endtask

    task automatic send_first(input int k);
        for (int i = 0; i < k; i++) send_byte(fr[i]);
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: run did not complete");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; start_i = 1'b0; stop_i = 1'b0;
        byte_vld_i = 1'b0; byte_i = 8'h00;
        clr_sb();
        repeat (3) @(negedge clk);
        chk({cmd_vld_o, crc_err_o, rx_err_o, pl_we_o} == 4'b0, "R1 in reset",
            int'({cmd_vld_o, crc_err_o, rx_err_o, pl_we_o}), 0);
        rst_n = 1'b1;
        settle();
        chk({cmd_vld_o, crc_err_o, rx_err_o, pl_we_o} == 4'b0, "R1 after reset",
            int'({cmd_vld_o, crc_err_o, rx_err_o, pl_we_o}), 0);

        // Good packets at every legal length (R2 R3 R4, R12 at zero)
        for (int len = 0; len <= MAXP; len++) begin
            build(8'(8'h80 + len), 8'(len * 3 + 1), len, len, 1'b0);
            clr_sb();
            pulse_start(); send_first(fr_n); pulse_stop(); settle();
            chk(n_vld == 1 && n_crc == 0 && n_rx == 0,
                len == 0 ? "R12 zero length accepted" : "R4 CRC match accepted", n_vld, 1);
            chk(got_feat == 8'(8'h80 + len) && got_op == 8'(len * 3 + 1),
                "R2 feature/command", int'({got_feat, got_op}),
                int'({8'(8'h80 + len), 8'(len * 3 + 1)}));
            chk(got_len == len, "R2 length MSB first", got_len, len);
            chk(n_we == len && we_bad == 0,
                len == 0 ? "R12 no payload write" : "R3 payload writes", n_we, len);
        end

        // Corrupted CRC at every legal length (R5)
        for (int len = 0; len <= MAXP; len++) begin
            build(8'h8A, 8'h02, len, len + 50, 1'b1);
            clr_sb();
            pulse_start(); send_first(fr_n); pulse_stop(); settle();
            chk(n_crc == 1 && n_vld == 0 && n_rx == 0, "R5 CRC mismatch", n_crc, 1);
        end

        // Illegal lengths (R6)
        for (int k = 0; k < 3; k++) begin
            int bad_len;
            bad_len = (k == 0) ? MAXP + 1 : (k == 1) ? 256 : 16'hFFFF;
            build(8'h51, 8'h08, bad_len, 0, 1'b0);
            clr_sb();
            pulse_start(); send_first(fr_n); pulse_stop(); settle();
            chk(n_rx == 1 && n_vld == 0 && n_crc == 0 && n_we == 0,
                "R6 length above limit", n_rx, 1);
        end

        // Stop after every partial prefix (R7)
        build(8'h80, 8'h02, 3, 7, 1'b0);
        for (int k = 0; k < fr_n; k++) begin
            clr_sb();
            pulse_start(); send_first(k); pulse_stop(); settle();
            chk(n_rx == 1 && n_vld == 0 && n_crc == 0, "R7 truncated packet", n_rx, 1);
        end

        // Byte after the CRC (R11)
        build(8'h80, 8'h01, 2, 9, 1'b0);
        fr[fr_n] = 8'h5A;
        clr_sb();
        pulse_start(); send_first(fr_n + 1); pulse_stop(); settle();
        chk(n_rx == 1 && n_vld == 0 && n_crc == 0, "R11 extra byte", n_rx, 1);

        // Restart mid-packet (R8)
        build(8'h8A, 8'h01, 4, 11, 1'b0);
        clr_sb();
        pulse_start();
        send_byte(8'h11); send_byte(8'h22); send_byte(8'h00); send_byte(8'h02);
        pulse_start(); send_first(fr_n); pulse_stop(); settle();
        chk(n_vld == 1 && n_rx == 0 && n_crc == 0, "R8 restart accepted", n_vld, 1);
        chk(got_len == 4 && n_we == 4 && we_bad == 0, "R8 restart payload", n_we, 4);

        // Bytes outside a packet (R9)
        clr_sb();
        for (int i = 0; i < 6; i++) send_byte(8'(i * 41));
        settle();
        chk(n_we == 0 && n_vld + n_crc + n_rx == 0, "R9 bytes with no start",
            n_we + n_vld + n_crc + n_rx, 0);
        clr_sb();
        pulse_start(); send_byte(8'h80); pulse_stop();
        for (int i = 0; i < 6; i++) send_byte(8'(i * 13 + 1));
        pulse_stop(); settle();
        chk(n_rx == 1 && n_we == 0 && n_vld + n_crc == 0, "R9 bytes after abort", n_rx, 1);

        chk(r10_bad == 0, "R10 result strobes exclusive", r10_bad, 0);

        summary();
        $finish;
    end

endmodule